// File: doc/BRIEF.md
# Gated Key-Loading Scan Chain

This block is a serial shift register that sits outside every core and hands each core a private key over one shared wire. The tester shifts the keys for all cores in, one bit per clock, through a single serial input. Each core's key input is tied to its own fixed group of consecutive cells, so where a core sits in the chain is what identifies it. The tester cannot address a core in any other way.

A global active-low inhibit input gates every cell output. While the inhibit is low, every output that reaches a core reads zero, whatever the flip-flops hold. As a result, no core can watch another core's key bits move past it. When all bits are in place, the tester raises the inhibit and every core sees its own segment at once. Pulling the inhibit low again blanks all outputs in the same cycle, and the stored contents are kept. The outputs only drive out of the chain: nothing on the core side feeds back into a cell. A full load of N cores with K-bit keys takes N×K shift clocks.

Top module: `keyscan_chain`

## Requirements
- R1: After reset, every cell holds zero. The key outputs then read zero even when the inhibit is released without any shifting.
- R2: On each clock with `shift_en` high, the chain moves one place toward the high-numbered cells. Cell 0 takes `ser_in` and cell i takes the old value of cell i-1.
- R3: While `inhibit_n` is low, `key_out` is all zeros whatever the cells hold, including during shifting.
- R4: While `inhibit_n` is high and reset is complete, `key_out[i]` equals cell i. Core c receives `key_out[c*KEY_W +: KEY_W]`.
- R5: Lowering `inhibit_n` blanks `key_out` within the same cycle, without waiting for a clock edge, and leaves the cells unchanged. Raising it again shows the same key values.
- R6: With `shift_en` low, the cells keep their values whatever `ser_in` does.
- R7: After exactly N×K shifts, the bit shifted in at step t (counting from 0) sits in cell N×K-1-t. Shifting a word W with its most significant bit first therefore makes `key_out` equal W.
- R8: Asserting `rst_n` at any time clears every cell. After reset, the outputs stay zero until new bits are shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Key-setup clock, the same rate as the test clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously inside the block |
| shift_en | input | 1 | Shift the chain by one cell on this clock |
| ser_in | input | 1 | Serial key bit entering cell 0 |
| inhibit_n | input | 1 | Active-low output inhibit; low forces every key output to zero |
| key_out | output | N_CORES*KEY_W | Gated cell outputs; core c uses bits [c*KEY_W +: KEY_W] |

## Verification
A shift takes effect at the rising edge where `shift_en` is sampled high. The bench drives its inputs just after an edge and checks the cells two time units after the next edge, so it sees exactly one register stage. The inhibit acts combinationally on the outputs. For this reason the bench checks blanking and restoring one time unit after moving `inhibit_n`, with no clock edge in between. After `rst_n` is released, the internal synchroniser holds the cells in reset for two more edges. The bench waits three edges before its first post-reset check.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;

  typedef enum logic {
    GATE_SHUT = 1'b0,
    GATE_OPEN = 1'b1
  } gate_state_e;

  function automatic int unsigned chain_len(input int unsigned n_cores,
                                            input int unsigned key_w);
    return n_cores * key_w;
  endfunction

  function automatic int unsigned seg_base(input int unsigned core_idx,
                                           input int unsigned key_w);
    return core_idx * key_w;
  endfunction

endpackage

// File: rtl/keyscan_rst_sync.sv
module keyscan_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/keyscan_segment.sv
module keyscan_segment #(
  parameter int unsigned SEG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             seg_in,
  output logic [SEG_W-1:0] seg_q,
  output logic             seg_out
);

  logic [SEG_W-1:0] cell_q;
  logic [SEG_W-1:0] cell_d;

  // next state: shift toward the high end when enabled
  always_comb begin
    cell_d = cell_q;
    if (shift_en) begin
      if (SEG_W > 1) begin
        cell_d = {cell_q[SEG_W-2:0], seg_in};
      end else begin
        cell_d = seg_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cell_q <= '0;
    end else begin
      cell_q <= cell_d;
    end
  end

  assign seg_q   = cell_q;
  assign seg_out = cell_q[SEG_W-1];

endmodule

// File: rtl/keyscan_out_gate.sv
module keyscan_out_gate
  import keyscan_pkg::*;
#(
  parameter int unsigned GATE_W = 8
) (
  input  gate_state_e       gate_i,
  input  logic [GATE_W-1:0] data_i,
  output logic [GATE_W-1:0] data_o
);

  always_comb begin
    if (gate_i == GATE_OPEN) begin
      data_o = data_i;
    end else begin
      data_o = '0;
    end
  end

endmodule

// File: rtl/keyscan_chain.sv
module keyscan_chain
  import keyscan_pkg::*;
#(
  parameter int unsigned N_CORES = 8,
  parameter int unsigned KEY_W   = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       shift_en,
  input  logic                       ser_in,
  input  logic                       inhibit_n,
  output logic [N_CORES*KEY_W-1:0]   key_out
);

  localparam int unsigned CHAIN_W = chain_len(N_CORES, KEY_W);

  logic               rst_sync_n;
  logic [CHAIN_W-1:0] chain_q;
  logic [N_CORES:0]   link;
  gate_state_e        gate_state;

  keyscan_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign link[0] = ser_in;

  for (genvar c = 0; c < N_CORES; c++) begin : g_seg
    keyscan_segment #(.SEG_W(KEY_W)) u_seg (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .shift_en (shift_en),
      .seg_in   (link[c]),
      .seg_q    (chain_q[seg_base(c, KEY_W) +: KEY_W]),
      .seg_out  (link[c+1])
    );
  end

  // outputs open only when reset is done and the tester has released the inhibit
  always_comb begin
    gate_state = (inhibit_n && rst_sync_n) ? GATE_OPEN : GATE_SHUT;
  end

  keyscan_out_gate #(.GATE_W(CHAIN_W)) u_gate (
    .gate_i (gate_state),
    .data_i (chain_q),
    .data_o (key_out)
  );

endmodule

// File: rtl/keyscan_chain_chk.sv
module keyscan_chain_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rst_sync_n,
  input logic         shift_en,
  input logic         ser_in,
  input logic         inhibit_n,
  input logic [W-1:0] chain_q,
  input logic [W-1:0] key_out
);

  // R1
  reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> (chain_q == '0 && key_out == '0));

  // R2
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    shift_en |=> (chain_q == {$past(chain_q[W-2:0]), $past(ser_in)}));

  // R3
  inhibit_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inhibit_n |-> (key_out == '0));

  // R4
  release_shows_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    inhibit_n |-> (key_out == chain_q));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !shift_en |=> $stable(chain_q));

  // R8
  reset_blank_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (key_out == '0));

endmodule

bind keyscan_chain keyscan_chain_chk #(.W(N_CORES*KEY_W)) u_keyscan_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .shift_en   (shift_en),
  .ser_in     (ser_in),
  .inhibit_n  (inhibit_n),
  .chain_q    (chain_q),
  .key_out    (key_out)
);

// File: tb/keyscan_chain_bench.sv
module keyscan_chain_bench;

  localparam int unsigned NC = 4;
  localparam int unsigned KW = 8;
  localparam int unsigned W  = NC * KW;
  localparam int unsigned NVEC = 6;
  localparam logic [W-1:0] VEC [NVEC] = '{
    32'hA5A5_F00F, 32'hFFFF_FFFF, 32'h0000_0001,
    32'h8000_0000, 32'h1234_5678, 32'hDEAD_BEEF
  };

  logic         clk;
  logic         rst_n;
  logic         shift_en;
  logic         ser_in;
  logic         inhibit_n;
  logic [W-1:0] key_out;

  int checks;
  int errors;
  int cycles;
  bit done;

  keyscan_chain #(.N_CORES(NC), .KEY_W(KW)) u_keyscan_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (shift_en),
    .ser_in    (ser_in),
    .inhibit_n (inhibit_n),
    .key_out   (key_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // one shift; inputs are driven just after an edge, result checked 2 units after the next
  task automatic shift_bit(input logic b);
    ser_in   = b;
    shift_en = 1'b1;
    @(posedge clk);
    #2;
    shift_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
  endtask

  task automatic load_word(input logic [W-1:0] word, input string req);
    inhibit_n = 1'b0;
    for (int t = 0; t < W; t++) begin
      shift_bit(word[W-1-t]);
      chk(req, key_out, '0);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
    end
  end

  initial begin
    checks = 0; errors = 0; cycles = 0; done = 1'b0;
    shift_en = 1'b0; ser_in = 1'b0; inhibit_n = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    do_reset();

    // R1: reset state, released without shifting
    chk("R1 inhibited", key_out, '0);
    inhibit_n = 1'b1; #1;
    chk("R1 released", key_out, '0);

    // table: R3 blank while loading, R7 and R4 placement after N*K shifts
    for (int v = 0; v < NVEC; v++) begin
      load_word(VEC[v], "R3");
      inhibit_n = 1'b1; #1;
      chk("R7", key_out, VEC[v]);
      for (int c = 0; c < NC; c++) begin
        chk("R4", W'(key_out[c*KW +: KW]), W'(VEC[v][c*KW +: KW]));
      end
      @(posedge clk); #2;
    end

    // R5: blank and restore without a clock edge
    inhibit_n = 1'b0; #1;
    chk("R5 blank", key_out, '0);
    inhibit_n = 1'b1; #1;
    chk("R5 restore", key_out, VEC[NVEC-1]);

    // R6: hold with shift_en low while ser_in toggles
    for (int i = 0; i < 5; i++) begin
      ser_in = i[0];
      @(posedge clk); #2;
      chk("R6", key_out, VEC[NVEC-1]);
    end

    // R2: single steps with outputs visible
    begin
      logic [W-1:0] exp;
      exp = VEC[NVEC-1];
      for (int i = 0; i < 4; i++) begin
        shift_bit(i[1]);
        exp = {exp[W-2:0], i[1]};
        chk("R2", key_out, exp);
      end
    end

    // R7 boundary: one shift short leaves the word offset by one
    load_word(32'hC3C3_0FF0, "R3 partial");
    inhibit_n = 1'b1; #1;
    chk("R7 full", key_out, 32'hC3C3_0FF0);
    inhibit_n = 1'b0;
    do_reset();
    inhibit_n = 1'b0;
    for (int t = 0; t < W - 1; t++) shift_bit(1'b1);
    inhibit_n = 1'b1; #1;
    chk("R7 short", key_out, 32'h7FFF_FFFF);

    // R8: reset mid-operation clears the cells
    inhibit_n = 1'b1;
    do_reset();
    chk("R8", key_out, '0);
    @(posedge clk); #2;
    chk("R8 stays", key_out, '0);

    summary();
  end

endmodule